// File: doc/BRIEF.md
# Non-multiplexed host port slave

This block lets an external host reach on-chip word memory and a small control register through a 16-bit non-multiplexed port. The port has a separate address bus, a bidirectional 16-bit data bus, a target-select pin, a read/write pin, an active-high data strobe and a mode pin. The host gets a ready handshake back. A control-register write can raise an interrupt request to the core or release the core from its boot hold.

Memory traffic goes through a shared internal memory bus as single-word requests. Each request is held until the bus arbiter grants it, so the ready latency has no upper bound. An optional bus holder keeps the last value written by the host on the data bus whenever nothing else drives the bus.

Top module: `hostPortSlave`

## Requirements
- R1: With `hostSel`=0 an access targets the control register. With `hostSel`=1 it targets memory at word address {extended field, `hostAddr`}.
- R2: The control register holds the extended-address field in bits [11:8], and a read returns that field. Bit 0 (interrupt) and bit 1 (release) are write-only. They and every other bit always read as 0, whatever the bus holder shows.
- R3: A control write with bit 0 set drives `dspIrq` high for exactly the one cycle after the edge that accepts the write. At all other times `dspIrq` is low.
- R4: When `bootMode`=1, `coreHold` is high from reset until a control write with bit 1 set, and it is low from the cycle after that write's accepting edge onward. When `bootMode`=0, `coreHold` stays low.
- R5: A read of the control register or of word address 0 raises `ready` in the cycle after the strobe is first sampled. A memory read raises it in the cycle after the grant. The read data is driven on `hostData` while `ready` and the strobe are both high.
- R6: On a write, `ready` stays low while the strobe is high. It then pulses for one cycle: in the cycle after the strobe is sampled low for control or address-0 writes, or in the cycle after the grant for memory writes.
- R7: `memReq` stays high with a stable address, data and direction until `memGnt` is sampled.
- R8: Word address 0 cannot be reached. A write to it issues no memory request and changes nothing. A read of it returns 0 and issues no request.
- R9: With `holderEn`=1, the data bus shows the last value the host wrote whenever neither the host nor a read drives it, whichever target that write had.
- R10: With `nonMux`=0, strobes are ignored: no request, no ready, no register change.
- R11: A strobe that arrives while a write is still pending is not accepted until that write completes. The pending write lands unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| nonMux | input | 1 | Mode pin, 1 selects non-multiplexed operation |
| bootMode | input | 1 | 1 holds the core until released by the host |
| holderEn | input | 1 | Enables the data bus holder |
| hostAddr | input | HOST_AW | Host word address |
| hostSel | input | 1 | 0 control register, 1 memory data |
| hostRnW | input | 1 | 1 read, 0 write |
| hostStb | input | 1 | Data strobe, active high |
| hostData | inout | DATA_W | Bidirectional host data bus |
| ready | output | 1 | Ready handshake to the host |
| dspIrq | output | 1 | One-cycle interrupt request to the core |
| coreHold | output | 1 | Holds the core in reset |
| memReq | output | 1 | Memory bus request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | MEM_AW | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid with the grant |
| memGnt | input | 1 | Memory bus grant |

## Verification
The bench counts falling edges from the one at which it raises or drops the strobe. A control or address-0 access must show `ready` at the first such edge. A memory access must show it at edge 2+g, where g is the number of idle cycles the bench's arbiter holds back the grant. `dspIrq` and `coreHold` are compared one time unit after every rising edge against a model that the access tasks update when the strobe is raised. This places the interrupt in exactly the cycle after acceptance. Memory contents, the held bus value and the absence of requests are sampled at falling edges between accesses.

// File: rtl/hpsPkg.sv
package hpsPkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RDREQ, S_RDDONE, S_WRHOLD, S_WRREQ, S_WRDONE
  } hpsState_e;

  typedef enum logic [1:0] {SRC_CTRL, SRC_MEM, SRC_ZERO} rdSrc_e;

  typedef struct packed {
    logic   accept;   // host access taken this cycle
    logic   isWrite;  // accepted access is a write
    logic   loadRd;   // load read-return register
    rdSrc_e rdSrc;    // source for loadRd
    logic   drive;    // drive read data on the host bus
  } hpsStrobe_t;

  localparam int IRQ_BIT = 0;
  localparam int REL_BIT = 1;
endpackage

// File: rtl/hpsControl.sv
module hpsControl
  import hpsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostStb,
  input  logic       hostRnW,
  input  logic       hostSel,
  input  logic       nonMux,
  input  logic       liveZero,
  input  logic       memGnt,
  output hpsStrobe_t stb,
  output logic       memReq,
  output logic       memWe,
  output logic       ready
);
  hpsState_e state, stateNext;
  logic skipMem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      skipMem <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && hostStb && nonMux && !hostRnW)
        skipMem <= !hostSel || liveZero;
    end
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    stb.rdSrc = SRC_CTRL;
    memReq    = 1'b0;
    memWe     = 1'b0;
    ready     = 1'b0;
    case (state)
      S_IDLE: begin
        if (hostStb && nonMux) begin
          stb.accept  = 1'b1;
          stb.isWrite = !hostRnW;
          if (!hostRnW) begin
            stateNext = S_WRHOLD;
          end else if (!hostSel) begin
            stb.loadRd = 1'b1;
            stb.rdSrc  = SRC_CTRL;
            stateNext  = S_RDDONE;
          end else if (liveZero) begin
            stb.loadRd = 1'b1;
            stb.rdSrc  = SRC_ZERO;
            stateNext  = S_RDDONE;
          end else begin
            stateNext = S_RDREQ;
          end
        end
      end
      S_RDREQ: begin
        memReq = 1'b1;
        if (memGnt) begin
          stb.loadRd = 1'b1;
          stb.rdSrc  = SRC_MEM;
          stateNext  = S_RDDONE;
        end
      end
      S_RDDONE: begin
        ready     = 1'b1;
        stb.drive = hostStb && nonMux;
        if (!hostStb) stateNext = S_IDLE;
      end
      S_WRHOLD: begin
        if (!hostStb) stateNext = skipMem ? S_WRDONE : S_WRREQ;
      end
      S_WRREQ: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memGnt) stateNext = S_WRDONE;
      end
      S_WRDONE: begin
        ready     = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end
endmodule

// File: rtl/hpsDatapath.sv
module hpsDatapath
  import hpsPkg::*;
#(
  parameter int HOST_AW = 16,
  parameter int XADDR_W = 4,
  parameter int DATA_W  = 16,
  parameter int XLSB    = 8,
  localparam int MEM_AW = HOST_AW + XADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpsStrobe_t        stb,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic              hostSel,
  input  logic              hostStb,
  input  logic              hostRnW,
  input  logic              holderEn,
  inout  wire  [DATA_W-1:0] hostData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              liveZero,
  output logic              dspIrq,
  output logic              released
);
  logic [XADDR_W-1:0] extAddr;
  logic [MEM_AW-1:0]  latAddr;
  logic [DATA_W-1:0]  latData, holdVal, rdReg, ctrlView, hostDataIn;
  logic               ctrlWr;

  assign hostDataIn = hostData;
  assign ctrlWr     = stb.accept && stb.isWrite && !hostSel;
  assign liveZero   = ({extAddr, hostAddr} == '0);

  always_comb begin
    ctrlView = '0;
    ctrlView[XLSB +: XADDR_W] = extAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extAddr  <= '0;
      latAddr  <= '0;
      latData  <= '0;
      holdVal  <= '0;
      rdReg    <= '0;
      dspIrq   <= 1'b0;
      released <= 1'b0;
    end else begin
      dspIrq <= ctrlWr && hostDataIn[IRQ_BIT];
      if (ctrlWr) begin
        extAddr <= hostDataIn[XLSB +: XADDR_W];
        if (hostDataIn[REL_BIT]) released <= 1'b1;
      end
      if (stb.accept) latAddr <= {extAddr, hostAddr};
      if (stb.accept && stb.isWrite) begin
        latData <= hostDataIn;
        holdVal <= hostDataIn;
      end
      if (stb.loadRd) begin
        case (stb.rdSrc)
          SRC_CTRL: rdReg <= ctrlView;
          SRC_MEM:  rdReg <= memRdata;
          default:  rdReg <= '0;
        endcase
      end
    end
  end

  assign memAddr  = latAddr;
  assign memWdata = latData;
  assign hostData = stb.drive ? rdReg
                  : (holderEn && !(hostStb && !hostRnW)) ? holdVal
                  : {DATA_W{1'bz}};
endmodule

// File: rtl/hostPortSlave.sv
module hostPortSlave
  import hpsPkg::*;
#(
  parameter int HOST_AW = 16,
  parameter int XADDR_W = 4,
  parameter int DATA_W  = 16,
  localparam int MEM_AW = HOST_AW + XADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nonMux,
  input  logic              bootMode,
  input  logic              holderEn,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic              hostSel,
  input  logic              hostRnW,
  input  logic              hostStb,
  inout  wire  [DATA_W-1:0] hostData,
  output logic              ready,
  output logic              dspIrq,
  output logic              coreHold,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memGnt
);
  hpsStrobe_t stb;
  logic liveZero, released;

  hpsControl ctrl_i (
    .clk(clk), .rstN(rstN), .hostStb(hostStb), .hostRnW(hostRnW),
    .hostSel(hostSel), .nonMux(nonMux), .liveZero(liveZero),
    .memGnt(memGnt), .stb(stb), .memReq(memReq), .memWe(memWe),
    .ready(ready)
  );

  hpsDatapath #(.HOST_AW(HOST_AW), .XADDR_W(XADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .hostAddr(hostAddr),
    .hostSel(hostSel), .hostStb(hostStb), .hostRnW(hostRnW),
    .holderEn(holderEn), .hostData(hostData), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .liveZero(liveZero),
    .dspIrq(dspIrq), .released(released)
  );

  assign coreHold = bootMode && !released;
endmodule

// File: rtl/hpsChecker.sv
module hpsChecker #(
  parameter int MEM_AW = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              dspIrq,
  input logic              coreHold,
  input logic              bootMode,
  input logic              memReq,
  input logic              memWe,
  input logic              memGnt,
  input logic [MEM_AW-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));
  // R3
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dspIrq |=> !dspIrq);
  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !coreHold && bootMode |=> !coreHold);
  // R4
  no_boot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bootMode |-> !coreHold);
  // R6
  wr_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !ready);
endmodule

bind hostPortSlave hpsChecker #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .ready(ready), .dspIrq(dspIrq),
  .coreHold(coreHold), .bootMode(bootMode), .memReq(memReq),
  .memWe(memWe), .memGnt(memGnt), .memAddr(memAddr), .memWdata(memWdata)
);

// File: tb/hostPortSlave_tb_top.sv
module hostPortSlave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic nonMux = 1'b1, bootMode = 1'b1, holderEn = 1'b0;
  logic [15:0] hostAddr = '0;
  logic hostSel = 1'b0, hostRnW = 1'b1, hostStb = 1'b0;
  logic tbOe = 1'b0;
  logic [15:0] tbData = '0;
  wire  [15:0] hostData;
  logic ready, dspIrq, coreHold, memReq, memWe, memGnt;
  logic [MEM_AW-1:0] memAddr;
  logic [15:0] memWdata, memRdata;

  int checks = 0, fails = 0, gDelay = 0, waitCnt = 0, reqCycles = 0;
  logic expIrq = 1'b0, expHold = 1'b1, modelOn = 1'b0;
  logic [15:0] mem [0:127];

  assign hostData = tbOe ? tbData : 16'hzzzz;
  always #(CLK_PERIOD/2) clk = ~clk;

  hostPortSlave dut_i (
    .clk(clk), .rstN(rstN), .nonMux(nonMux), .bootMode(bootMode),
    .holderEn(holderEn), .hostAddr(hostAddr), .hostSel(hostSel),
    .hostRnW(hostRnW), .hostStb(hostStb), .hostData(hostData),
    .ready(ready), .dspIrq(dspIrq), .coreHold(coreHold), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memGnt(memGnt)
  );

  function automatic int idx(input logic [MEM_AW-1:0] a);
    return int'({a[17:16], a[4:0]});
  endfunction

  // memory bus model: grant after gDelay waiting cycles
  assign memGnt   = memReq && (waitCnt == gDelay);
  assign memRdata = mem[idx(memAddr)];
  always @(posedge clk) begin
    if (!memReq || memGnt) waitCnt <= 0; else waitCnt <= waitCnt + 1;
    if (memReq) reqCycles <= reqCycles + 1;
    if (memReq && memWe && memGnt) mem[idx(memAddr)] <= memWdata;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock reference comparison of interrupt and hold
  always begin
    @(posedge clk); #1;
    if (modelOn) begin
      check(dspIrq === expIrq, "R3 dspIrq", {31'b0, dspIrq}, {31'b0, expIrq});
      check(coreHold === expHold, "R4 coreHold", {31'b0, coreHold}, {31'b0, expHold});
    end
  end

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic hostWrite(input logic sel, input logic [15:0] addr, input logic [15:0] data,
                           input int expLat, input string tag);
    int n;
    @(negedge clk);
    hostSel = sel; hostAddr = addr; hostRnW = 1'b0; tbData = data; tbOe = 1'b1; hostStb = 1'b1;
    expIrq = !sel && data[0] && nonMux;
    if (!sel && data[1] && nonMux) expHold = 1'b0;
    @(negedge clk); expIrq = 1'b0;
    check(ready === 1'b0, {tag, " R6 ready low in strobe"}, {31'b0, ready}, 0);
    @(negedge clk);
    check(ready === 1'b0, {tag, " R6 ready low in strobe"}, {31'b0, ready}, 0);
    hostStb = 1'b0; tbOe = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!ready && n < 40);
    check(n == expLat, {tag, " R6 write ready latency"}, n, expLat);
    @(negedge clk);
    check(ready === 1'b0, {tag, " R6 single ready pulse"}, {31'b0, ready}, 0);
  endtask

  task automatic hostRead(input logic sel, input logic [15:0] addr, input logic [15:0] exp,
                          input int expLat, input string tag);
    int n;
    @(negedge clk);
    hostSel = sel; hostAddr = addr; hostRnW = 1'b1; hostStb = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!ready && n < 40);
    check(n == expLat, {tag, " R5 read ready latency"}, n, expLat);
    check(hostData === exp, {tag, " read data"}, {16'b0, hostData}, {16'b0, exp});
    hostStb = 1'b0;
    @(negedge clk);
    check(ready === 1'b0, {tag, " R5 ready ends with strobe"}, {31'b0, ready}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    int r0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mem[0] = 16'h5A5A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ready === 1'b0 && dspIrq === 1'b0 && memReq === 1'b0, "reset outputs idle",
          {29'b0, ready, dspIrq, memReq}, 0);
    check(coreHold === 1'b1, "R4 held after reset", {31'b0, coreHold}, 1);
    modelOn = 1'b1;

    hostWrite(1'b0, 16'h0, 16'h0001, 1, "R3 irq write");
    hostRead(1'b0, 16'h0, 16'h0000, 1, "R2 write-only bits read zero");
    hostWrite(1'b0, 16'h0, 16'h0302, 1, "R4 release + ext");
    hostRead(1'b0, 16'h0, 16'h0300, 1, "R2 ext field readback");
    hostWrite(1'b0, 16'h0, 16'h0000, 1, "R1 ext clear");

    hostWrite(1'b1, 16'h5, 16'hFACE, 2, "R1 mem write");
    check(mem[5] === 16'hFACE, "R1 mem[5] written", {16'b0, mem[5]}, 32'hFACE);
    gDelay = 3;
    hostRead(1'b1, 16'h5, 16'hFACE, 5, "R7 delayed grant read");
    hostWrite(1'b1, 16'h6, 16'hCAFE, 5, "R7 delayed grant write");
    check(mem[6] === 16'hCAFE, "R7 mem[6] written", {16'b0, mem[6]}, 32'hCAFE);
    gDelay = 0;

    hostWrite(1'b0, 16'h0, 16'h0200, 1, "R1 ext=2");
    hostWrite(1'b1, 16'h7, 16'hBEEF, 2, "R1 ext write");
    check(mem[idx(20'h20007)] === 16'hBEEF && mem[7] === 16'h0000, "R1 extended address used",
          {16'b0, mem[idx(20'h20007)]}, 32'hBEEF);
    hostRead(1'b1, 16'h7, 16'hBEEF, 2, "R1 ext read");
    hostWrite(1'b0, 16'h0, 16'h0000, 1, "R1 ext=0");

    r0 = reqCycles;
    hostWrite(1'b1, 16'h0, 16'h1111, 1, "R8 addr0 write");
    hostRead(1'b1, 16'h0, 16'h0000, 1, "R8 addr0 read");
    check(mem[0] === 16'h5A5A, "R8 addr0 unchanged", {16'b0, mem[0]}, 32'h5A5A);
    check(reqCycles == r0, "R8 no request", reqCycles, r0);

    // R10: mode pin low, strobe ignored
    r0 = reqCycles;
    @(negedge clk);
    nonMux = 1'b0; hostSel = 1'b1; hostAddr = 16'h5; hostRnW = 1'b0; tbData = 16'h0BAD; tbOe = 1'b1; hostStb = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(ready === 1'b0, "R10 no ready", {31'b0, ready}, 0);
    end
    hostStb = 1'b0; tbOe = 1'b0;
    repeat (3) @(negedge clk);
    check(reqCycles == r0, "R10 no request", reqCycles, r0);
    nonMux = 1'b1;
    hostRead(1'b1, 16'h5, 16'hFACE, 2, "R10 memory untouched");

    // R9 bus holder
    holderEn = 1'b1;
    hostWrite(1'b1, 16'h9, 16'hDEAD, 2, "R9 mem write");
    check(hostData === 16'hDEAD, "R9 holder after data write", {16'b0, hostData}, 32'hDEAD);
    hostWrite(1'b0, 16'h0, 16'h00F0, 1, "R9 ctrl write");
    check(hostData === 16'h00F0, "R9 holder after ctrl write", {16'b0, hostData}, 32'h00F0);
    hostRead(1'b0, 16'h0, 16'h0000, 1, "R2 reads zero with holder");
    holderEn = 1'b0;

    // R11 stall during a pending write
    gDelay = 6;
    @(negedge clk);
    hostSel = 1'b1; hostAddr = 16'hA; hostRnW = 1'b0; tbData = 16'h1234; tbOe = 1'b1; hostStb = 1'b1;
    repeat (2) @(negedge clk);
    hostStb = 1'b0; tbOe = 1'b0;
    @(negedge clk);
    hostAddr = 16'hB; tbData = 16'h5678; tbOe = 1'b1; hostStb = 1'b1;
    r0 = 1;
    while (!ready && r0 < 40) begin @(negedge clk); r0++; end
    check(r0 == 8, "R11 pending write ready", r0, 8);
    check(mem[10] === 16'h1234, "R11 pending write intact", {16'b0, mem[10]}, 32'h1234);
    repeat (3) @(negedge clk);
    check(ready === 1'b0, "R11 second write held off", {31'b0, ready}, 0);
    hostStb = 1'b0; tbOe = 1'b0;
    r0 = 0;
    do begin @(negedge clk); r0++; end while (!ready && r0 < 40);
    check(r0 == 8, "R11 second write ready", r0, 8);
    check(mem[11] === 16'h5678 && mem[10] === 16'h1234, "R11 both writes landed",
          {mem[10], mem[11]}, 32'h12345678);
    gDelay = 0;

    repeat (2) @(negedge clk);
    finishUp();
  end
endmodule